// File: doc/BRIEF.md
# Microcode Address Sequencer

This block steps through a microprogram held in a small on-chip microcode ROM. Every clock it selects one 16-bit microcode address from three sources: a jump target, the 12-bit entry address of a newly dispatched opcode, or its own address register. It presents the selected address to the ROM and to an incrementer in the same cycle. On the clock edge that registers the ROM word, the address register takes the selected address plus one. Without any redirect, the sequencer therefore walks one microword per clock.

Fetched words pass through two output stages. The first stage holds the word just read from the ROM. The second stage holds the word being handed to the decode logic. This lets the fetch of the next word overlap with the hand-off of the current one. A valid flag moves with each stage. A jump or dispatch discards the word that was fetched in sequence just before it, and any word marked invalid is shown as an all-zero no-op. A stall freezes the whole pipeline.

Top module: `ucode_seq`

## Requirements
- R1: While reset is active (and until the first clock after it is released), `uword` is 0, `uword_valid` is 0 and `cur_addr` is 0. The address register resets to 0, so the first word fetched after reset comes from address 0.
- R2: With `jump`, `dispatch` and `stall` low, each clock fetches the address held in the address register and loads that register with the address plus one. The word selected at clock edge k appears on `uword` with `uword_valid` high after edge k+1, provided the pipeline was already carrying valid words.
- R3: Selector priority is `jump` (use `jump_tgt`) first, then `dispatch` (use `entry_addr`), then the address register.
- R4: The dispatch entry address is zero-extended: entry address e selects address {4'b0000, e}.
- R5: ROM contents: the word for address a, with i = a[7:0] (the low ROM_AW bits), is {i, ~i, i ^ 8'h3C, 8'hA5}.
- R6: On a clock edge where `jump` or `dispatch` is accepted (stall low), the word moving into the second stage is marked invalid. An invalid second stage drives `uword` = 32'h0000_0000 with `uword_valid` low.
- R7: While `stall` is high, the address register and both stages hold. Outputs do not change, and `jump`/`dispatch` in those cycles have no effect on the addresses fetched after the stall ends.
- R8: The address register wraps: after fetching 16'hFFFF, the next sequential fetch is address 16'h0000.
- R9: `cur_addr` is the address from which the word now in the second stage was fetched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dispatch | input | 1 | Start a new microprogram at `entry_addr` |
| entry_addr | input | 12 | Microprogram entry address from the opcode lookup |
| jump | input | 1 | Redirect the sequence to `jump_tgt` |
| jump_tgt | input | 16 | Jump target address |
| stall | input | 1 | Freeze the address register and both output stages |
| uword | output | 32 | Microword in the second stage, or 0 when invalid |
| uword_valid | output | 1 | Second-stage word is valid |
| cur_addr | output | 16 | Fetch address of the second-stage word |

## Verification
An address selected at clock edge k is in the first stage after edge k and reaches `uword`, `uword_valid` and `cur_addr` after edge k+1. The invalidation caused by a redirect at edge k shows up on the outputs after that same edge. The driver task applies each stimulus shortly after a rising edge and, from a behavioural model of R1 to R9, queues the expected outputs due after the next edge, tagged with that cycle number. The monitor samples at the falling edge and compares only the entries whose due cycle has arrived. This keeps every comparison one register stage after its stimulus and clear of the active edge.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int ENTRY_W = 12;
  localparam int ADDR_W  = 16;
  localparam int WORD_W  = 32;
  localparam int ROM_AW  = 8;

  // Pattern of the built-in microprogram, indexed by the low address bits
  function automatic logic [31:0] rom_word(input logic [7:0] idx);
    return {idx, ~idx, idx ^ 8'h3C, 8'hA5};
  endfunction
endpackage

// File: rtl/useq_addr_sel.sv
`timescale 1ns/1ps
module useq_addr_sel #(
  parameter int ENTRY_W = useq_pkg::ENTRY_W,
  parameter int ADDR_W  = useq_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall,
  input  logic               jump,
  input  logic [ADDR_W-1:0]  jump_tgt,
  input  logic               dispatch,
  input  logic [ENTRY_W-1:0] entry_addr,
  output logic [ADDR_W-1:0]  sel_addr,
  output logic               redirect
);
  localparam int PAD_W = ADDR_W - ENTRY_W;

  logic [ADDR_W-1:0] rar_q;
  logic [ADDR_W-1:0] rar_d;
  logic              rar_en;

  always_comb begin
    if (jump)          sel_addr = jump_tgt;
    else if (dispatch) sel_addr = {{PAD_W{1'b0}}, entry_addr};
    else               sel_addr = rar_q;
  end

  assign redirect = jump | dispatch;
  assign rar_en   = ~stall;
  assign rar_d    = sel_addr + ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rar_q <= '0;
    else if (rar_en) rar_q <= rar_d;
  end

  // R2: the register holds the previously applied address plus one
  a_r2_rar_step: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> rar_q == $past(sel_addr) + ADDR_W'(1));

  // R8: the sequence wraps at the top of the address space
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && sel_addr == {ADDR_W{1'b1}}) |=> rar_q == '0);

  // R7: the address register holds during a stall
  a_r7_rar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(rar_q));
endmodule

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom #(
  parameter int ROM_AW = useq_pkg::ROM_AW,
  parameter int WORD_W = useq_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ROM_AW-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ROM_AW;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign mem[g] = WORD_W'(useq_pkg::rom_word(8'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_data <= '0;
    else if (en) rd_data <= mem[rd_idx];
  end

  // R7: the first output stage keeps its word while reads are disabled
  a_r7_rom_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rd_data));
endmodule

// File: rtl/useq_pipe.sv
`timescale 1ns/1ps
module useq_pipe #(
  parameter int ADDR_W = useq_pkg::ADDR_W,
  parameter int WORD_W = useq_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [WORD_W-1:0] s1_word,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s1_valid,
  output logic [WORD_W-1:0] uword,
  output logic              uword_valid,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [WORD_W-1:0] NOP_WORD = '0;

  logic              en;
  logic              v1_d, v2_d, v2_q;
  logic [ADDR_W-1:0] a1_d, a2_d, a2_q;
  logic [WORD_W-1:0] w2_d, w2_q;

  assign en = ~stall;

  always_comb begin
    v1_d = 1'b1;
    a1_d = sel_addr;
    w2_d = s1_word;
    a2_d = s1_addr;
    v2_d = s1_valid & ~redirect;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      v2_q     <= 1'b0;
      a2_q     <= '0;
      w2_q     <= '0;
    end else if (en) begin
      s1_valid <= v1_d;
      s1_addr  <= a1_d;
      v2_q     <= v2_d;
      a2_q     <= a2_d;
      w2_q     <= w2_d;
    end
  end

  assign uword       = v2_q ? w2_q : NOP_WORD;
  assign uword_valid = v2_q;
  assign cur_addr    = a2_q;

  // R6: an accepted redirect voids the word entering stage two
  a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && redirect) |=> !uword_valid && uword == NOP_WORD);

  // R7: outputs frozen during a stall
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(uword) && $stable(uword_valid) && $stable(cur_addr));

  // R9: stage-one address moves to cur_addr on an enabled clock
  a_r9_addr_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> cur_addr == $past(s1_addr));

  // R2: a valid stage-one word without redirect arrives valid
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && s1_valid && !redirect) |=> uword_valid);
endmodule

// File: rtl/ucode_seq.sv
`timescale 1ns/1ps
module ucode_seq #(
  parameter int ENTRY_W = useq_pkg::ENTRY_W,
  parameter int ADDR_W  = useq_pkg::ADDR_W,
  parameter int WORD_W  = useq_pkg::WORD_W,
  parameter int ROM_AW  = useq_pkg::ROM_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dispatch,
  input  logic [ENTRY_W-1:0] entry_addr,
  input  logic               jump,
  input  logic [ADDR_W-1:0]  jump_tgt,
  input  logic               stall,
  output logic [WORD_W-1:0]  uword,
  output logic               uword_valid,
  output logic [ADDR_W-1:0]  cur_addr
);
  logic              rst_meta, rst_sync;
  logic [ADDR_W-1:0] sel_addr;
  logic              redirect;
  logic [WORD_W-1:0] s1_word;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  useq_addr_sel #(.ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_sync),
    .stall      (stall),
    .jump       (jump),
    .jump_tgt   (jump_tgt),
    .dispatch   (dispatch),
    .entry_addr (entry_addr),
    .sel_addr   (sel_addr),
    .redirect   (redirect)
  );

  useq_rom #(.ROM_AW(ROM_AW), .WORD_W(WORD_W)) u_rom (
    .clk     (clk),
    .rst_n   (rst_sync),
    .en      (~stall),
    .rd_idx  (sel_addr[ROM_AW-1:0]),
    .rd_data (s1_word)
  );

  useq_pipe #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_sync),
    .stall       (stall),
    .redirect    (redirect),
    .sel_addr    (sel_addr),
    .s1_word     (s1_word),
    .s1_addr     (s1_addr),
    .s1_valid    (s1_valid),
    .uword       (uword),
    .uword_valid (uword_valid),
    .cur_addr    (cur_addr)
  );

  // R3: jump wins over everything else
  a_r3_jump_first: assert property (@(posedge clk) disable iff (!rst_sync)
    (jump && !stall) |=> s1_addr == $past(jump_tgt));

  // R4: dispatch entry is zero-extended when no jump is present
  a_r4_zero_ext: assert property (@(posedge clk) disable iff (!rst_sync)
    (dispatch && !jump && !stall) |=> s1_addr == ADDR_W'($past(entry_addr)));

  // R1: nothing valid leaves the block while held in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_sync |-> !uword_valid && cur_addr == '0);
endmodule

// File: tb/ucode_seq_tb.sv
`timescale 1ns/1ps
module ucode_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dispatch, jump, stall;
  logic [11:0] entry_addr;
  logic [15:0] jump_tgt;
  logic [31:0] uword;
  logic        uword_valid;
  logic [15:0] cur_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  typedef struct {
    int          due;
    logic [31:0] w;
    logic        v;
    logic [15:0] a;
    string       tag;
  } exp_t;
  exp_t q[$];

  // model state
  logic [15:0] m_rar, m_a1, m_a2;
  logic [31:0] m_w1, m_w2;
  logic        m_v1, m_v2;

  ucode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .dispatch(dispatch), .entry_addr(entry_addr),
    .jump(jump), .jump_tgt(jump_tgt), .stall(stall),
    .uword(uword), .uword_valid(uword_valid), .cur_addr(cur_addr)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] exp_word(input logic [15:0] a);
    logic [7:0] i;
    i = a[7:0];
    return {i, ~i, i ^ 8'h3C, 8'hA5};
  endfunction

  task automatic check(input string tag, input logic [31:0] w, input logic v,
                       input logic [15:0] a);
    n_chk++;
    if (uword !== w || uword_valid !== v || cur_addr !== a) begin
      n_bad++;
      $display("FAIL %s: got word=%h valid=%b addr=%h, expected word=%h valid=%b addr=%h",
               tag, uword, uword_valid, cur_addr, w, v, a);
    end
  endtask

  task automatic step(input logic j, input logic [15:0] t, input logic d,
                      input logic [11:0] e, input logic s, input string tag);
    logic [15:0] sel;
    exp_t it;
    @(posedge clk);
    #2;
    jump = j; jump_tgt = t; dispatch = d; entry_addr = e; stall = s;
    if (!s) begin
      sel  = j ? t : (d ? {4'b0000, e} : m_rar);
      m_v2 = m_v1 & ~(j | d);
      m_w2 = m_w1;
      m_a2 = m_a1;
      m_w1 = exp_word(sel);
      m_a1 = sel;
      m_v1 = 1'b1;
      m_rar = sel + 16'd1;
    end
    it.due = cyc + 1;
    it.w   = m_v2 ? m_w2 : 32'h0;
    it.v   = m_v2;
    it.a   = m_a2;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic seq(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 16'h0, 1'b0, 12'h0, 1'b0, tag);
  endtask

  // monitor: compares entries whose due cycle has arrived
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t it;
        it = q.pop_front();
        check(it.tag, it.w, it.v, it.a);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got no end of run, expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; stall = 1'b1; jump = 1'b0; dispatch = 1'b0;
    jump_tgt = '0; entry_addr = '0;
    m_rar = 0; m_a1 = 0; m_a2 = 0; m_w1 = 0; m_w2 = 0; m_v1 = 0; m_v2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset held", 32'h0, 1'b0, 16'h0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 after release under stall", 32'h0, 1'b0, 16'h0);

    // R1/R2/R5: sequential run from address 0
    seq(8, "R2 R5 sequential from 0 (R1 start)");

    // R4/R6: dispatch, then sequence
    step(1'b0, 16'h0, 1'b1, 12'hABC, 1'b0, "R6 dispatch flush");
    seq(4, "R4 dispatch entry 0ABC sequence");
    step(1'b0, 16'h0, 1'b1, 12'hFFF, 1'b0, "R6 dispatch flush 2");
    seq(3, "R4 zero-extension of FFF");

    // R3: jump and dispatch together
    step(1'b1, 16'h1234, 1'b1, 12'h055, 1'b0, "R3 jump beats dispatch");
    seq(3, "R3 continue after jump 1234");

    // R7: stall with redirects requested
    step(1'b0, 16'h0, 1'b0, 12'h0, 1'b1, "R7 stall hold");
    step(1'b1, 16'h4000, 1'b0, 12'h0, 1'b1, "R7 jump ignored in stall");
    step(1'b0, 16'h0, 1'b1, 12'h321, 1'b1, "R7 dispatch ignored in stall");
    seq(4, "R7 sequence resumes after stall");

    // R8: wrap
    step(1'b1, 16'hFFFE, 1'b0, 12'h0, 1'b0, "R8 jump near top");
    seq(5, "R8 wrap FFFF to 0000 R9");

    // back-to-back redirects
    step(1'b1, 16'h0800, 1'b0, 12'h0, 1'b0, "R6 jump a");
    step(1'b1, 16'h0900, 1'b0, 12'h0, 1'b0, "R6 jump b");
    step(1'b0, 16'h0, 1'b1, 12'h010, 1'b0, "R6 dispatch c");
    seq(3, "R9 after back-to-back redirects");

    // mixed pattern
    lfsr = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3], {lfsr[7:0], lfsr[15:8]}, lfsr[1] & lfsr[4],
           lfsr[15:4], lfsr[2] & lfsr[5], "R2 R3 R6 R7 mixed");
    end
    seq(3, "R2 drain");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule